// File: doc/BRIEF.md
# Port Width Adapter with Byte-Order Swap

This block sits between a 36-bit FIFO word path and an external port that may be 36, 18 or 9 bits wide. An internal word is four 9-bit bytes. Call them A, B, C, D, with A in bits 35:27 and D in bits 8:0. In the write direction, narrow port transfers are gathered into one word and pushed to the FIFO. In the read direction, one popped word is handed out as a series of narrow port transfers. In both directions the byte order of the word can be rearranged in one of four ways.

The port size and the lane side (high or low lanes) are set by static-looking control pins. The block stages these pins and applies them only between words. The swap mode is taken from its pin when each word starts. A size code of all ones marks a mailbox access. In that mode the FIFO path is closed and a status output tells the surrounding logic to route the port elsewhere.

Every data interface is valid/ready. A transfer happens on a rising edge where both valid and ready are high. For back-pressure:
- A write port beat that is not the last of a word is always accepted.
- The last write beat is accepted only in the same cycle as the FIFO push, so `wr_ready` follows `push_ready` there.
- `pop_ready` is asserted only on the final read beat, together with `rd_ready`. The popped word must stay on `pop_data` until then.

Top module: `bus_match_unit`

## Requirements
- R1: Size code 00 moves a word in one 36-bit transfer, 01 in two 18-bit transfers and 10 in four 9-bit transfers. The FIFO is pushed (`push_valid`) or popped (`pop_ready`) only on the final transfer of a word, exactly once per word.
- R2: `size_sel` and `endian_sel` are registered on a rising edge. The next rising edge makes them active, provided no word is partly transferred. A change driven before edge N is therefore in force after edge N+1, and not after edge N alone.
- R3: While the active size code is 11, `mbx_access` is high. `wr_ready`, `push_valid`, `rd_valid` and `pop_ready` are all low, whatever is on the other inputs.
- R4: With `endian_sel` LOW, 18-bit transfers use port bits 35:18 and 9-bit transfers use bits 35:27. With it HIGH, they use bits 17:0 and 8:0. On reads the unused lanes of `rd_data` are zero. On writes the unused lanes of `wr_data` do not affect the pushed word.
- R5: With `endian_sel` LOW, the most significant half or byte of the port-side word moves first. With it HIGH, the least significant moves first.
- R6: Swap code 00 leaves ABCD unchanged. Code 01 gives DCBA, code 10 gives CDAB and code 11 gives BADC. On writes, the pushed word is the swapped form of the word assembled from the port. On reads, the port sees the swapped form of the popped word.
- R7: The swap code is taken from `swap_sel` on the first transfer of each word. It is held for the rest of that word, whatever `swap_sel` does after that.
- R8: A size or endian change requested partway through a word has no effect on that word. It takes effect on the edge that completes the word, once the other direction is also between words.
- R9: After reset the active setting is 36-bit with `endian_sel` LOW, and both directions stand at the start of a word.
- R10: A non-final write beat is always accepted. The final write beat is accepted only when `push_ready` is high. `rd_valid` follows `pop_valid` whenever the mode is not mailbox.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| size_sel | input | 2 | Requested size: 00 36-bit, 01 18-bit, 10 9-bit, 11 mailbox |
| endian_sel | input | 1 | LOW: high lanes, MS first; HIGH: low lanes, LS first |
| swap_sel | input | 2 | Byte-order mode, sampled at word start |
| wr_valid | input | 1 | Port write beat valid |
| wr_ready | output | 1 | Port write beat accepted |
| wr_data | input | 36 | Port write data |
| push_valid | output | 1 | Assembled word valid toward FIFO |
| push_ready | input | 1 | FIFO can take a word |
| push_data | output | 36 | Assembled, swapped word |
| pop_valid | input | 1 | FIFO word available |
| pop_ready | output | 1 | FIFO word consumed |
| pop_data | input | 36 | FIFO head word |
| rd_valid | output | 1 | Port read beat valid |
| rd_ready | input | 1 | Port read beat taken |
| rd_data | output | 36 | Port read data, unused lanes zero |
| mbx_access | output | 1 | Active size code is mailbox |

## Verification
The assertions rely on three things about the inputs. The FIFO keeps `pop_data` steady until `pop_ready` completes a word. Valid signals are not withdrawn in the middle of a handshake. Control pins change only at points the bench chooses. The stimulus holds one popped word and one write valid until each beat is accepted, while ready signals toggle at random. It randomizes `swap_sel` on every beat after the first, so that the word-start capture is tested, and it never drives the mailbox code during a partial word. Size and endian changes are made at word boundaries, except in one directed case that changes them deliberately in mid-word.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int NLANE = 4;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_MBOX = 2'b11
  } size_e;

  typedef struct packed {
    logic       hit;
    logic [1:0] lane;
  } route_t;

  // Index permutation: out byte k = in byte (k ^ mask)
  function automatic logic [1:0] swap_mask(logic [1:0] mode);
    case (mode)
      2'b01:   return 2'd3;
      2'b10:   return 2'd2;
      2'b11:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] final_beat(size_e s);
    case (s)
      SZ_HALF: return 2'd1;
      SZ_BYTE: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // Which port lane carries internal byte k on a given beat
  function automatic route_t route(size_e s, logic le, logic [1:0] beat, logic [1:0] k);
    route_t r;
    logic   half;
    logic [1:0] slot;
    r = '0;
    case (s)
      SZ_LONG: begin
        r.hit  = 1'b1;
        r.lane = k;
      end
      SZ_HALF: begin
        half   = le ? beat[0] : ~beat[0];
        r.hit  = (k[1] == half);
        r.lane = {~le, k[0]};
      end
      SZ_BYTE: begin
        slot   = le ? beat : 2'd3 - beat;
        r.hit  = (k == slot);
        r.lane = le ? 2'd0 : 2'd3;
      end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bmu_cfg.sv
module bmu_cfg
  import bmu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic [1:0] size_in,
  input  logic  endian_in,
  input  logic  boundary,
  output size_e size_act,
  output logic  endian_act
);
  size_e size_stg;
  logic  endian_stg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_stg   <= SZ_LONG;
      endian_stg <= 1'b0;
      size_act   <= SZ_LONG;
      endian_act <= 1'b0;
    end else begin
      size_stg   <= size_e'(size_in);
      endian_stg <= endian_in;
      if (boundary) begin
        size_act   <= size_stg;
        endian_act <= endian_stg;
      end
    end
  end
endmodule

// File: rtl/bmu_pack.sv
module bmu_pack
  import bmu_pkg::*;
#(
  parameter int BYTE_W = 9
) (
  input  logic  clk,
  input  logic  rst_n,
  input  size_e size_act,
  input  logic  endian_act,
  input  logic [1:0] swap_in,
  input  logic  wr_valid,
  output logic  wr_ready,
  input  logic [NLANE*BYTE_W-1:0] wr_data,
  output logic  push_valid,
  input  logic  push_ready,
  output logic [NLANE*BYTE_W-1:0] push_data,
  output logic  idle_next
);
  logic [NLANE-1:0][BYTE_W-1:0] port_b, acc, merged, out_b;
  logic [1:0] cnt, cnt_nxt, swap_r, mode, xr;
  logic active, last, fire;

  assign port_b = wr_data;
  assign active = (size_act != SZ_MBOX);
  assign last   = (cnt == final_beat(size_act));
  assign mode   = (cnt == 2'd0) ? swap_in : swap_r;
  assign xr     = swap_mask(mode);

  always_comb begin
    route_t rt;
    for (int k = 0; k < NLANE; k++) begin
      rt        = route(size_act, endian_act, cnt, 2'(k));
      merged[k] = rt.hit ? port_b[rt.lane] : acc[k];
    end
    for (int k = 0; k < NLANE; k++) begin
      out_b[k] = merged[2'(k) ^ xr];
    end
  end

  assign push_data  = out_b;
  assign wr_ready   = active & (~last | push_ready);
  assign push_valid = active & wr_valid & last;
  assign fire       = wr_valid & wr_ready;
  assign cnt_nxt    = fire ? (last ? 2'd0 : cnt + 2'd1) : cnt;
  assign idle_next  = (cnt_nxt == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      acc    <= '0;
      swap_r <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (fire) acc <= merged;
      if (fire && cnt == 2'd0) swap_r <= swap_in;
    end
  end
endmodule

// File: rtl/bmu_unpack.sv
module bmu_unpack
  import bmu_pkg::*;
#(
  parameter int BYTE_W = 9
) (
  input  logic  clk,
  input  logic  rst_n,
  input  size_e size_act,
  input  logic  endian_act,
  input  logic [1:0] swap_in,
  input  logic  pop_valid,
  output logic  pop_ready,
  input  logic [NLANE*BYTE_W-1:0] pop_data,
  output logic  rd_valid,
  input  logic  rd_ready,
  output logic [NLANE*BYTE_W-1:0] rd_data,
  output logic  idle_next
);
  logic [NLANE-1:0][BYTE_W-1:0] pop_b, sw_b, out_b;
  logic [1:0] cnt, cnt_nxt, swap_r, mode, xr;
  logic active, last, fire;

  assign pop_b  = pop_data;
  assign active = (size_act != SZ_MBOX);
  assign last   = (cnt == final_beat(size_act));
  assign mode   = (cnt == 2'd0) ? swap_in : swap_r;
  assign xr     = swap_mask(mode);

  always_comb begin
    route_t rt;
    for (int k = 0; k < NLANE; k++) begin
      sw_b[k] = pop_b[2'(k) ^ xr];
    end
    out_b = '0;
    for (int k = 0; k < NLANE; k++) begin
      rt = route(size_act, endian_act, cnt, 2'(k));
      if (rt.hit) out_b[rt.lane] = sw_b[k];
    end
  end

  assign rd_data   = out_b;
  assign rd_valid  = active & pop_valid;
  assign pop_ready = active & rd_ready & last;
  assign fire      = rd_valid & rd_ready;
  assign cnt_nxt   = fire ? (last ? 2'd0 : cnt + 2'd1) : cnt;
  assign idle_next = (cnt_nxt == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      swap_r <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (fire && cnt == 2'd0) swap_r <= swap_in;
    end
  end
endmodule

// File: rtl/bus_match_unit.sv
module bus_match_unit
  import bmu_pkg::*;
#(
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               size_sel,
  input  logic                     endian_sel,
  input  logic [1:0]               swap_sel,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [NLANE*BYTE_W-1:0]  wr_data,
  output logic                     push_valid,
  input  logic                     push_ready,
  output logic [NLANE*BYTE_W-1:0]  push_data,
  input  logic                     pop_valid,
  output logic                     pop_ready,
  input  logic [NLANE*BYTE_W-1:0]  pop_data,
  output logic                     rd_valid,
  input  logic                     rd_ready,
  output logic [NLANE*BYTE_W-1:0]  rd_data,
  output logic                     mbx_access
);
  size_e size_act;
  logic  endian_act;
  logic  wr_idle_next, rd_idle_next;

  bmu_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_in    (size_sel),
    .endian_in  (endian_sel),
    .boundary   (wr_idle_next & rd_idle_next),
    .size_act   (size_act),
    .endian_act (endian_act)
  );

  bmu_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_act   (size_act),
    .endian_act (endian_act),
    .swap_in    (swap_sel),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_data    (wr_data),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_data  (push_data),
    .idle_next  (wr_idle_next)
  );

  bmu_unpack #(.BYTE_W(BYTE_W)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_act   (size_act),
    .endian_act (endian_act),
    .swap_in    (swap_sel),
    .pop_valid  (pop_valid),
    .pop_ready  (pop_ready),
    .pop_data   (pop_data),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_data    (rd_data),
    .idle_next  (rd_idle_next)
  );

  assign mbx_access = (size_act == SZ_MBOX);
endmodule

// File: rtl/bmu_chk.sv
module bmu_chk
  import bmu_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] size_act,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       push_valid,
  input logic       push_ready,
  input logic       pop_valid,
  input logic       pop_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       mbx_access
);
  logic [1:0] wc, rc, lim;
  logic wr_hs, rd_hs;

  assign lim   = final_beat(size_e'(size_act));
  assign wr_hs = wr_valid & wr_ready;
  assign rd_hs = rd_valid & rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wc <= '0;
      rc <= '0;
    end else begin
      if (wr_hs) wc <= (wc == lim) ? 2'd0 : wc + 2'd1;
      if (rd_hs) rc <= (rc == lim) ? 2'd0 : rc + 2'd1;
    end
  end

  // R1
  push_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready) |-> (wr_hs && wc == lim));

  // R1
  no_early_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hs && wc != lim) |-> !push_valid);

  // R1
  pop_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && pop_ready) |-> (rd_hs && rc == lim));

  // R8
  wr_size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wc != 2'd0 && !wr_hs) |=> $stable(size_act));

  // R8
  rd_size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rc != 2'd0 && !rd_hs) |=> $stable(size_act));

  // R3
  mbx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbx_access |-> (!wr_ready && !push_valid && !rd_valid && !pop_ready));
endmodule

bind bus_match_unit bmu_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .size_act   (size_act),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .push_valid (push_valid),
  .push_ready (push_ready),
  .pop_valid  (pop_valid),
  .pop_ready  (pop_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .mbx_access (mbx_access)
);

// File: tb/bus_match_unit_bench.sv
module bus_match_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] size_sel = 2'b00, swap_sel = 2'b00;
  logic endian_sel = 1'b0;
  logic wr_valid = 1'b0, push_ready = 1'b0, pop_valid = 1'b0, rd_ready = 1'b0;
  logic [35:0] wr_data = '0, pop_data = '0;
  logic wr_ready, push_valid, pop_ready, rd_valid, mbx_access;
  logic [35:0] push_data, rd_data;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_match_unit u_bus_match_unit (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .endian_sel(endian_sel),
    .swap_sel(swap_sel), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_data(pop_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .mbx_access(mbx_access)
  );

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] reorder(input logic [35:0] w, input logic [1:0] sw);
    case (sw)
      2'b01:   return {w[8:0], w[17:9], w[26:18], w[35:27]};
      2'b10:   return {w[17:0], w[35:18]};
      2'b11:   return {w[26:18], w[35:27], w[8:0], w[17:9]};
      default: return w;
    endcase
  endfunction

  function automatic int beats(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  // Port image of one beat: lanes per R4, order per R5, swap per R6
  function automatic logic [35:0] port_img(input logic [35:0] w, input logic [1:0] sz,
                                           input logic le, input logic [1:0] sw, input int beat);
    logic [35:0] s;
    logic [17:0] h;
    logic [8:0]  b;
    int idx;
    s = reorder(w, sw);
    if (sz == 2'b00) return s;
    if (sz == 2'b01) begin
      h = (le ? (beat == 0) : (beat == 1)) ? s[17:0] : s[35:18];
      return le ? {18'b0, h} : {h, 18'b0};
    end
    idx = le ? beat : 3 - beat;
    b = s[idx*9 +: 9];
    return le ? {27'b0, b} : {b, 27'b0};
  endfunction

  function automatic logic [35:0] lane_mask(input logic [1:0] sz, input logic le);
    if (sz == 2'b00) return '1;
    if (sz == 2'b01) return le ? 36'h0_0003_FFFF : 36'hF_FFFC_0000;
    return le ? 36'h0_0000_01FF : 36'hF_F800_0000;
  endfunction

  task automatic set_cfg(input logic [1:0] sz, input logic le);
    size_sel = sz;
    endian_sel = le;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_word(input logic [35:0] p, input logic [1:0] sz, input logic le,
                            input logic [1:0] sw, input int b_from, input int b_to,
                            input string tag);
    int nb;
    logic acc;
    nb = beats(sz);
    for (int bt = b_from; bt <= b_to; bt++) begin
      swap_sel = (bt == 0) ? sw : 2'($urandom);
      wr_data = port_img(p, sz, le, sw, bt) | ({$urandom, $urandom} & ~lane_mask(sz, le));
      wr_valid = 1'b1;
      do begin
        push_ready = 1'($urandom);
        #1;
        check({tag, " R1 push only on last beat"}, {35'b0, push_valid}, {35'b0, bt == nb-1});
        check({tag, " R10 write ready"}, {35'b0, wr_ready},
              {35'b0, (bt == nb-1) ? push_ready : 1'b1});
        if (push_valid && push_ready)
          check({tag, " R6 R7 pushed word"}, push_data, p);
        acc = wr_ready;
        @(posedge clk);
        @(negedge clk);
      end while (!acc);
    end
    wr_valid = 1'b0;
  endtask

  task automatic read_word(input logic [35:0] p, input logic [1:0] sz, input logic le,
                           input logic [1:0] sw, input string tag);
    int nb;
    logic r;
    nb = beats(sz);
    pop_valid = 1'b1;
    pop_data = p;
    for (int bt = 0; bt < nb; bt++) begin
      swap_sel = (bt == 0) ? sw : 2'($urandom);
      do begin
        r = 1'($urandom);
        rd_ready = r;
        #1;
        check({tag, " R10 rd_valid"}, {35'b0, rd_valid}, 36'd1);
        if (r) begin
          check({tag, " R4 R5 R6 R7 read beat"}, rd_data, port_img(p, sz, le, sw, bt));
          check({tag, " R1 pop on last beat"}, {35'b0, pop_ready}, {35'b0, bt == nb-1});
        end else begin
          check({tag, " R1 no pop without rd_ready"}, {35'b0, pop_ready}, 36'd0);
        end
        @(posedge clk);
        @(negedge clk);
      end while (!r);
    end
    pop_valid = 1'b0;
    rd_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [1:0] sz, sw;
    logic le;
    void'($urandom(32'd24681));
    // R9: reset state, with a byte-size request held during reset
    size_sel = 2'b10;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 mbx_access after reset", {35'b0, mbx_access}, 36'd0);
    wr_valid = 1'b1;
    push_ready = 1'b0;
    #1;
    check("R9 long word active after reset", {35'b0, push_valid}, 36'd1);
    wr_valid = 1'b0;
    @(negedge clk);
    set_cfg(2'b00, 1'b0);

    // R2: change applies on the second edge, not the first
    size_sel = 2'b01;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b1;
    push_ready = 1'b0;
    #1;
    check("R2 still long after first edge", {35'b0, push_valid}, 36'd1);
    @(posedge clk);
    @(negedge clk);
    check("R2 half size after second edge", {35'b0, push_valid}, 36'd0);
    wr_valid = 1'b0;
    @(negedge clk);
    write_word(36'h1_2345_6789, 2'b01, 1'b0, 2'b00, 0, 1, "R2");

    // R3: mailbox code closes the FIFO path
    set_cfg(2'b11, 1'b0);
    wr_valid = 1'b1; push_ready = 1'b1; pop_valid = 1'b1; rd_ready = 1'b1;
    #1;
    check("R3 mbx_access", {35'b0, mbx_access}, 36'd1);
    check("R3 path blocked", {32'b0, wr_ready, push_valid, rd_valid, pop_ready}, 36'd0);
    wr_valid = 1'b0; push_ready = 1'b0; pop_valid = 1'b0; rd_ready = 1'b0;
    @(negedge clk);

    // R8: size change mid-word waits for the word to finish
    set_cfg(2'b10, 1'b0);
    write_word(36'hA_BCDE_F012, 2'b10, 1'b0, 2'b01, 0, 1, "R8 first half");
    size_sel = 2'b00;
    repeat (3) @(negedge clk);
    write_word(36'hA_BCDE_F012, 2'b10, 1'b0, 2'b01, 2, 3, "R8 remainder");
    write_word(36'h5_0A0A_1234, 2'b00, 1'b0, 2'b10, 0, 0, "R8 long after boundary");

    // Random mix over all sizes, sides and swap modes
    for (int it = 0; it < 48; it++) begin
      sz = 2'($urandom_range(0, 2));
      le = 1'($urandom);
      sw = 2'($urandom);
      set_cfg(sz, le);
      for (int n = 0; n < 3; n++)
        write_word({$urandom, $urandom}, sz, le, sw, 0, beats(sz) - 1, "rand write");
      for (int n = 0; n < 3; n++)
        read_word({$urandom, $urandom}, sz, le, sw, "rand read");
    end

    // Directed swap corners on a known pattern, 9-bit big-endian read
    set_cfg(2'b10, 1'b0);
    for (int m = 0; m < 4; m++)
      read_word(36'h1_0080_6050, 2'b10, 1'b0, 2'(m), "R6 corner");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule